// File: doc/BRIEF.md
# Thermal alarm stage detector

This block watches a digitised die temperature, given in millidegrees Celsius, and sorts it into one of four alarm stages (0 to 3). The three stage boundaries sit 20 degrees apart. The lowest boundary is 105 C plus 5 C times a 2-bit threshold setting. The temperature is looked at only on a sampling tick, and only while the monitor is switched on. The current stage is reported in a status register. When the stage changes, the block raises a one-cycle interrupt. It also drives two shutdown requests for the upper stages.

Software reaches the block through a byte-wide register port. Writes are synchronous. Reads are combinational on the address. Two identification registers let a driver tell the block apart from others and learn which status encoding is in use. A build parameter picks that encoding:

- **Generation 1** reports the stage directly.
- **Generation 2** reports a 3-bit state. The state folds onto the four stages and marks an upward crossing with an odd value for one sample.

Top module: `thermal_stage_alarm`

## Requirements
- R1: After reset the control register (0x40), the alarm control register (0x46) and the stage all read zero, and `irq`, `shdn_s2` and `shdn_s3` are low.
- R2: Address 0x04 reads 0x09. Address 0x05 reads 0x08 when GEN=1 and 0x09 when GEN=2. Any unmapped address reads 0x00.
- R3: With threshold setting t (0x40 bits 1:0), let B = 105000 + 5000*t. A sample gives stage 3 for temp >= B+40000, stage 2 for temp >= B+20000, stage 1 for temp >= B, and stage 0 otherwise.
- R4: The stage changes only at a clock edge where `sample_tick` is high and the monitor-enable bit (0x46 bit 7) is set. At any other edge it holds.
- R5: With GEN=1 the status register (0x08) holds the stage in bits 1:0, and its other bits read 0.
- R6: With GEN=2 the status register holds a 3-bit state in bits 6:4, and its other bits read 0. States 0..7 mean stages 0,1,1,2,2,3,3,3.
  - On a rise to stage s the state becomes 2s-1.
  - A further sample at the same stage moves it to 2s.
  - A fall to stage s sets 2s directly.
  - Stage 0 is state 0.
- R7: `irq` is high for exactly the one cycle after a sampling edge at which the reported stage changed. A state change that keeps the stage (odd to even) raises no interrupt.
- R8: `shdn_s2` is high when the stage is 2 or more and the override bit (0x40 bit 6) is clear. `shdn_s3` is high at stage 3 whatever the override bit holds.
- R9: Address 0x40 keeps only bits 6, 3 and 1:0 of a write, and address 0x46 keeps only bit 7. Other bits read 0. Writes to read-only addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register address for reads and writes |
| reg_wr | input | 1 | Write strobe, captured at the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| temp_mdeg | input | TEMP_W | Die temperature in millidegrees C |
| sample_tick | input | 1 | One-cycle strobe that triggers a comparison |
| irq | output | 1 | Stage-change interrupt pulse |
| shdn_s2 | output | 1 | Stage-2 shutdown request |
| shdn_s3 | output | 1 | Stage-3 shutdown request |

## Verification
- **Stage, status and interrupt.** A sampling tick caught at one clock edge updates the stage, the status read-back and `irq` at that same edge. The bench therefore drives the tick on a falling edge and reads the results at the next falling edge.
- **Shutdown outputs.** These follow the stored stage and override bit without an extra register. A shutdown check made after a control write or a tick is due at the next falling edge.
- **Register writes.** These land at the edge that samples `reg_wr`. Read-backs are combinational, so the bench reads them 1 time unit after setting the address, well away from any edge.

// File: rtl/ta_pkg.sv
package ta_pkg;

    localparam logic [7:0] ADDR_ID      = 8'h04;
    localparam logic [7:0] ADDR_VARIANT = 8'h05;
    localparam logic [7:0] ADDR_STATUS  = 8'h08;
    localparam logic [7:0] ADDR_CTRL    = 8'h40;
    localparam logic [7:0] ADDR_MON     = 8'h46;

    localparam logic [7:0] ID_VALUE     = 8'h09;
    localparam logic [7:0] CTRL_MASK    = 8'h4B;

    typedef struct packed {
        logic [1:0] thresh;
        logic       rate;
        logic       ovr;
        logic       mon_en;
        logic [2:0] code;
        logic       irq;
    } ta_state_t;

    // Reported stage for a stored status code
    function automatic logic [1:0] stage_of(input logic [2:0] code, input int gen);
        if (gen == 1) begin
            return code[1:0];
        end
        case (code)
            3'd0:       return 2'd0;
            3'd1, 3'd2: return 2'd1;
            3'd3, 3'd4: return 2'd2;
            default:    return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/ta_stage_cmp.sv
module ta_stage_cmp #(
    parameter int TEMP_W     = 18,
    parameter int BASE_MDEG  = 105000,
    parameter int STEP_MDEG  = 5000,
    parameter int STAGE_MDEG = 20000
) (
    input  logic [TEMP_W-1:0] temp_mdeg,
    input  logic [1:0]        thresh,
    output logic [1:0]        raw_stage
);
    localparam int NSTAGE = 3;

    logic [31:0]       temp_ext;
    logic [NSTAGE-1:0] above;

    assign temp_ext = {{(32-TEMP_W){1'b0}}, temp_mdeg};

    for (genvar k = 0; k < NSTAGE; k++) begin : g_bound
        logic [31:0] bound;
        assign bound    = 32'(BASE_MDEG) + 32'(STEP_MDEG) * {30'd0, thresh} + 32'(STAGE_MDEG * k);
        assign above[k] = (temp_ext >= bound);
    end

    always_comb begin
        if (above[2])      raw_stage = 2'd3;
        else if (above[1]) raw_stage = 2'd2;
        else if (above[0]) raw_stage = 2'd1;
        else               raw_stage = 2'd0;
    end
endmodule

// File: rtl/ta_state_next.sv
module ta_state_next
    import ta_pkg::*;
#(
    parameter int GEN = 2
) (
    input  logic [1:0] raw_stage,
    input  logic [2:0] cur_code,
    output logic [2:0] nxt_code
);
    if (GEN == 1) begin : g_gen1
        assign nxt_code = {1'b0, raw_stage};
    end else begin : g_gen2
        logic [1:0] cur_stage;
        assign cur_stage = stage_of(cur_code, GEN);
        always_comb begin
            if (raw_stage > cur_stage) begin
                nxt_code = ({1'b0, raw_stage} << 1) - 3'd1;
            end else if (raw_stage == cur_stage) begin
                nxt_code = cur_code[0] ? cur_code + 3'd1 : cur_code;
            end else begin
                nxt_code = {1'b0, raw_stage} << 1;
            end
        end
    end
endmodule

// File: rtl/ta_status_fmt.sv
module ta_status_fmt #(
    parameter int GEN = 2
) (
    input  logic [2:0] code,
    output logic [7:0] status_byte,
    output logic [7:0] variant_byte
);
    if (GEN == 1) begin : g_gen1
        assign status_byte  = {6'd0, code[1:0]};
        assign variant_byte = 8'h08;
    end else begin : g_gen2
        assign status_byte  = {1'b0, code, 4'd0};
        assign variant_byte = 8'h09;
    end
endmodule

// File: rtl/thermal_stage_alarm.sv
module thermal_stage_alarm
    import ta_pkg::*;
#(
    parameter int GEN        = 2,
    parameter int TEMP_W     = 18,
    parameter int BASE_MDEG  = 105000,
    parameter int STEP_MDEG  = 5000,
    parameter int STAGE_MDEG = 20000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [TEMP_W-1:0] temp_mdeg,
    input  logic              sample_tick,
    output logic              irq,
    output logic              shdn_s2,
    output logic              shdn_s3
);
    ta_state_t  st_d, st_q;
    logic [1:0] raw_stage;
    logic [2:0] nxt_code;
    logic [7:0] status_byte;
    logic [7:0] variant_byte;
    logic [1:0] cur_stage;
    logic [2:0] code_w;
    logic       ovr_w;

    ta_stage_cmp #(
        .TEMP_W(TEMP_W), .BASE_MDEG(BASE_MDEG),
        .STEP_MDEG(STEP_MDEG), .STAGE_MDEG(STAGE_MDEG)
    ) u_cmp (
        .temp_mdeg(temp_mdeg), .thresh(st_q.thresh), .raw_stage(raw_stage)
    );

    ta_state_next #(.GEN(GEN)) u_next (
        .raw_stage(raw_stage), .cur_code(st_q.code), .nxt_code(nxt_code)
    );

    ta_status_fmt #(.GEN(GEN)) u_fmt (
        .code(st_q.code), .status_byte(status_byte), .variant_byte(variant_byte)
    );

    assign cur_stage = stage_of(st_q.code, GEN);
    assign code_w    = st_q.code;
    assign ovr_w     = st_q.ovr;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (reg_wr) begin
            case (reg_addr)
                ADDR_CTRL: begin
                    st_d.thresh = reg_wdata[1:0];
                    st_d.rate   = reg_wdata[3];
                    st_d.ovr    = reg_wdata[6];
                end
                ADDR_MON:  st_d.mon_en = reg_wdata[7];
                default:   ;
            endcase
        end
        if (sample_tick && st_q.mon_en) begin
            st_d.code = nxt_code;
            st_d.irq  = (stage_of(nxt_code, GEN) != cur_stage);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_ID:      reg_rdata = ID_VALUE;
            ADDR_VARIANT: reg_rdata = variant_byte;
            ADDR_STATUS:  reg_rdata = status_byte;
            ADDR_CTRL:    reg_rdata = {1'b0, st_q.ovr, 2'b00, st_q.rate, 1'b0, st_q.thresh};
            ADDR_MON:     reg_rdata = {st_q.mon_en, 7'd0};
            default:      reg_rdata = 8'h00;
        endcase
    end

    assign irq     = st_q.irq;
    assign shdn_s2 = (cur_stage >= 2'd2) && !st_q.ovr;
    assign shdn_s3 = (cur_stage == 2'd3);
endmodule

// File: rtl/ta_checker.sv
module ta_checker #(
    parameter int GEN = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sample_tick,
    input logic       irq,
    input logic       shdn_s2,
    input logic       shdn_s3,
    input logic [2:0] code,
    input logic       ovr
);
    // R4
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sample_tick) |-> $stable(code));

    // R7
    irq_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(sample_tick));

    // R8
    s2_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_s2 |-> !ovr);

    // R8
    s3_implies_s2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shdn_s3 && !ovr) |-> shdn_s2);

    // R6
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (GEN == 1) ? (code <= 3'd3) : (code != 3'd7));
endmodule

bind thermal_stage_alarm ta_checker #(.GEN(GEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .irq(irq),
    .shdn_s2(shdn_s2), .shdn_s3(shdn_s3), .code(code_w), .ovr(ovr_w)
);

// File: tb/thermal_stage_alarm_bench.sv
module thermal_stage_alarm_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    reg_addr = 8'h00;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_wdata = 8'h00;
    logic [TW-1:0] temp_mdeg = '0;
    logic          sample_tick = 1'b0;
    logic [7:0]    rd2, rd1;
    logic          irq2, irq1, s2_2, s2_1, s3_2, s3_1;
    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    thermal_stage_alarm #(.GEN(2), .TEMP_W(TW)) u_thermal_stage_alarm (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(rd2), .temp_mdeg(temp_mdeg),
        .sample_tick(sample_tick), .irq(irq2), .shdn_s2(s2_2), .shdn_s3(s3_2)
    );

    thermal_stage_alarm #(.GEN(1), .TEMP_W(TW)) u_thermal_stage_alarm_g1 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(rd1), .temp_mdeg(temp_mdeg),
        .sample_tick(sample_tick), .irq(irq1), .shdn_s2(s2_1), .shdn_s3(s3_1)
    );

    // {threshold setting, temperature, expected stage}
    localparam logic [21:0] VEC [10] = '{
        {2'd0, 18'd104999, 2'd0}, {2'd0, 18'd105000, 2'd1},
        {2'd0, 18'd125000, 2'd2}, {2'd0, 18'd145000, 2'd3},
        {2'd1, 18'd109999, 2'd0}, {2'd1, 18'd110000, 2'd1},
        {2'd2, 18'd134999, 2'd1}, {2'd3, 18'd160000, 2'd3},
        {2'd3, 18'd139999, 2'd1}, {2'd2, 18'd155000, 2'd3}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v2, output logic [7:0] v1);
        reg_addr = a;
        #1;
        v2 = rd2; v1 = rd1;
    endtask

    task automatic tick();
        @(negedge clk);
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v2, v1;
        do_reset();

        // R1 reset state
        rd(8'h40, v2, v1); check("R1 ctrl", v2, 0);
        rd(8'h46, v2, v1); check("R1 mon", v2, 0);
        rd(8'h08, v2, v1); check("R1 status g2", v2, 0); check("R1 status g1", v1, 0);
        check("R1 outputs", {irq2, s2_2, s3_2, irq1, s2_1, s3_1}, 0);

        // R2 identification
        rd(8'h04, v2, v1); check("R2 id", v2, 8'h09); check("R2 id g1", v1, 8'h09);
        rd(8'h05, v2, v1); check("R2 variant g2", v2, 8'h09); check("R2 variant g1", v1, 8'h08);
        rd(8'h10, v2, v1); check("R2 unmapped", v2, 0);

        // R4 tick while monitor disabled
        temp_mdeg = 18'd150000;
        tick();
        rd(8'h08, v2, v1); check("R4 disabled tick", v1, 0);
        check("R4 disabled irq", irq1, 0);

        // R9 write masks
        wr(8'h46, 8'hFF);
        rd(8'h46, v2, v1); check("R9 mon mask", v2, 8'h80);
        rd(8'h08, v2, v1); check("R4 no tick hold", v1, 0);
        wr(8'h40, 8'hFF);
        rd(8'h40, v2, v1); check("R9 ctrl mask", v2, 8'h4B);
        wr(8'h04, 8'h55);
        rd(8'h04, v2, v1); check("R9 read-only id", v2, 8'h09);
        wr(8'h08, 8'h33);
        rd(8'h08, v2, v1); check("R9 read-only status", v1, 0);

        // R3 / R5 threshold table on the generation-1 instance
        for (int i = 0; i < 10; i++) begin
            wr(8'h40, {6'd0, VEC[i][21:20]});
            temp_mdeg = VEC[i][19:2];
            tick();
            rd(8'h08, v2, v1);
            check($sformatf("R3 R5 vector %0d", i), v1, {6'd0, VEC[i][1:0]});
        end

        // R6 / R7 / R8 generation-2 sequence
        do_reset();
        wr(8'h46, 8'h80);
        wr(8'h40, 8'h00);
        temp_mdeg = 18'd115000;
        tick();
        rd(8'h08, v2, v1); check("R6 rise state1", v2, 8'h10);
        check("R7 irq on rise", irq2, 1); check("R7 irq g1", irq1, 1);
        tick();
        rd(8'h08, v2, v1); check("R6 settle state2", v2, 8'h20);
        check("R7 no irq odd to even", irq2, 0);
        check("R7 no irq same stage g1", irq1, 0);
        temp_mdeg = 18'd150000;
        tick();
        rd(8'h08, v2, v1); check("R6 rise state5", v2, 8'h50); check("R5 stage3", v1, 8'h03);
        check("R8 s2 at stage3", s2_2, 1); check("R8 s3 at stage3", s3_2, 1);
        tick();
        rd(8'h08, v2, v1); check("R6 settle state6", v2, 8'h60);
        wr(8'h40, 8'h40);
        @(negedge clk);
        check("R8 override s2", s2_2, 0); check("R8 s3 ignores override", s3_2, 1);
        temp_mdeg = 18'd130000;
        tick();
        rd(8'h08, v2, v1); check("R6 fall state4", v2, 8'h40);
        check("R7 irq on fall", irq2, 1);
        check("R8 s3 off at stage2", s3_2, 0); check("R8 s2 overridden", s2_1, 0);
        wr(8'h40, 8'h00);
        @(negedge clk);
        check("R8 s2 at stage2", s2_2, 1);
        temp_mdeg = 18'd100000;
        tick();
        rd(8'h08, v2, v1); check("R6 fall state0", v2, 8'h00);
        check("R7 irq to stage0", irq1, 1);
        check("R8 outputs low at stage0", {s2_2, s3_2}, 0);
        @(negedge clk);
        check("R7 single cycle", irq2, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule